// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps the time of day and the calendar date in packed BCD registers. A free-running oscillator level, sampled in the system clock domain, drives a binary prescaler. Every rising edge of that level advances the prescaler by one step. When the prescaler wraps, a one-cycle second tick is produced, and that tick advances the seconds, minutes, hours, day of week, date, month and year registers. The hour register works in either a 24-hour or a 12-hour encoding. Month lengths and leap years are handled in hardware, and a century bit toggles each time the two-digit year wraps.

A host writes and reads the registers through a simple one-cycle port. A write to the seconds register restarts the prescaler, so the next second boundary falls exactly one full prescaler period after that write. A control register holds an active-high halt bit, which freezes counting and raises a sticky stop flag. It also holds a two-bit square-wave rate selector. The square-wave output is taken straight from the prescaler taps or from the oscillator level.

Top module: `bcd_rtc_core`

## Requirements
- R1: Seconds (address 0) and minutes (address 1) count in packed BCD from 00 to 59. A wrap of seconds advances minutes, and a wrap of minutes advances the hour.
- R2: With hour bit 6 = 0 (24-hour), the hour register (address 2) counts 00 to 23 in BCD, using bit 5 as the tens digit for 20 to 23. The step from 23 to 00 advances the day.
- R3: With hour bit 6 = 1 (12-hour), bits 4:0 count 12, 01 … 11, and bit 5 is the PM flag (1 = PM). Bit 5 flips on the step from 11 to 12, and the day advances only on the step from 11 PM to 12 AM.
- R4: The date (address 4) wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other non-February months. The month (address 5, bits 4:0) wraps from 12 to 01 and advances the year.
- R5: February ends at 29 when the BCD year (address 6) is divisible by 4, with 00 included, and at 28 otherwise.
- R6: The year counts 00 to 99 in BCD. Month bit 7 is a century bit that toggles on the step from 99 to 00 and is otherwise held.
- R7: The day of week (address 3) advances with each day rollover and wraps from 7 to 1.
- R8: A write to seconds clears the prescaler. The next second tick comes after exactly 2^DIV_BITS oscillator rising edges, and the prescaler MSB (the 1 Hz wave) rises after half that count.
- R9: Control register (address 7) bits 1:0 select the square wave. 00 gives the prescaler MSB (1 Hz), 01 gives prescaler bit 2 (4.096 kHz), 10 gives prescaler bit 1 (8.192 kHz), and 11 gives the oscillator level (32.768 kHz).
- R10: After reset the registers read: time 00:00:00 in 24-hour mode, day 1, date 01, month 01, year 00, control 0x03, and status (address 8) 0x80.
- R11: Control bit 7 = 1 halts the prescaler and the counting and forces the square wave low. A 0→1 change of this bit sets status bit 7. Status bit 7 clears only when written with 0; writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_phase | input | 1 | Oscillator level sampled in the clk domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address (0–8) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address (0–8) |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| sqw_out | output | 1 | Square-wave output |

## Verification
The hardest states to reach from the ports are the rare calendar boundaries: the year 99 wrap that flips the century bit, February 29 in a year ending 00, and the 11 PM to 12 AM step in 12-hour mode. A free-running clock would need simulated years to get there. The bench instead loads every time field with the value one second short of the boundary. Because the seconds write restarts the prescaler, the bench knows the exact oscillator edge on which the tick fires. The prescaler width is reduced to 4 bits, so a second lasts only 16 oscillator periods.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [3:0] A_SEC  = 4'd0;
  localparam logic [3:0] A_MIN  = 4'd1;
  localparam logic [3:0] A_HOUR = 4'd2;
  localparam logic [3:0] A_DOW  = 4'd3;
  localparam logic [3:0] A_DATE = 4'd4;
  localparam logic [3:0] A_MON  = 4'd5;
  localparam logic [3:0] A_YEAR = 4'd6;
  localparam logic [3:0] A_CTRL = 4'd7;
  localparam logic [3:0] A_STAT = 4'd8;

  localparam int RATE_W = 2;

  typedef struct packed {
    logic       carry;
    logic [7:0] val;
  } bcd_step_t;

  // one BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // increment with wrap from 'last' to 'first'
  function automatic bcd_step_t bcd_wrap(input logic [7:0] v, input logic [7:0] last,
                                         input logic [7:0] first);
    bcd_step_t r;
    r.carry = (v == last);
    r.val   = r.carry ? first : bcd_inc(v);
    return r;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [7:0] yr);
    return (bcd_to_bin(yr) % 7'd4) == 7'd0;
  endfunction

  // last valid BCD date of a month
  function automatic logic [7:0] month_end(input logic [4:0] mo, input logic [7:0] yr);
    case (mo)
      5'h02:                     return leap_year(yr) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
      default:                   return 8'h31;
    endcase
  endfunction

  // hour step; bit6 = 12-hour mode, bit5 = PM flag or tens bit
  function automatic bcd_step_t hour_advance(input logic [6:0] h);
    bcd_step_t  r;
    logic [7:0] hr12;
    logic       pm;
    if (!h[6]) begin
      r = bcd_wrap({2'b00, h[5:0]}, 8'h23, 8'h00);
    end else begin
      hr12    = {3'b000, h[4:0]};
      pm      = h[5];
      r.carry = 1'b0;
      if (hr12 == 8'h12) begin
        hr12 = 8'h01;
      end else if (hr12 == 8'h11) begin
        hr12    = 8'h12;
        r.carry = pm;
        pm      = ~pm;
      end else begin
        hr12 = bcd_inc(hr12);
      end
      r.val = {1'b0, 1'b1, pm, hr12[4:0]};
    end
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_BITS = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                osc_phase,
  input  logic                halt,
  input  logic                div_clr,
  output logic [DIV_BITS-1:0] div_q,
  output logic                sec_tick
);
  localparam logic [DIV_BITS-1:0] DIV_LAST = '1;

  logic osc_d;
  logic osc_rise;
  logic cnt_en;

  assign osc_rise = osc_phase & ~osc_d;
  assign cnt_en   = osc_rise & ~halt;
  assign sec_tick = cnt_en & ~div_clr & (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      osc_d <= 1'b0;
      div_q <= '0;
    end else begin
      osc_d <= osc_phase;
      if (div_clr)     div_q <= '0;
      else if (cnt_en) div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              stat_wr,
  input  logic              wr_halt,
  input  logic [RATE_W-1:0] wr_rate,
  output logic              halt_q,
  output logic [RATE_W-1:0] rate_q,
  output logic              stop_flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_q      <= 1'b0;
      rate_q      <= '1;
      stop_flag_q <= 1'b1;
    end else begin
      if (ctrl_wr) begin
        halt_q <= wr_halt;
        rate_q <= wr_rate;
        if (wr_halt && !halt_q) stop_flag_q <= 1'b1;
      end
      // wr_halt carries data bit 7 for the status address as well
      if (stat_wr && !wr_halt) stop_flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_sqw_mux.sv
module rtc_sqw_mux
  import rtc_pkg::*;
(
  input  logic [2:0]        taps,
  input  logic              osc_phase,
  input  logic [RATE_W-1:0] rate,
  input  logic              halt,
  output logic              sqw
);
  logic sel;

  always_comb begin
    case (rate)
      2'b00:   sel = taps[2];
      2'b01:   sel = taps[1];
      2'b10:   sel = taps[0];
      default: sel = osc_phase;
    endcase
  end

  assign sqw = sel & ~halt;
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       sec_tick,
  output logic       cal_adv,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hour_q,
  output logic [7:0] dow_q,
  output logic [7:0] date_q,
  output logic [7:0] mon_q,
  output logic [7:0] year_q
);
  logic      pend_q;
  logic      sec_wr;
  bcd_step_t s_sec, s_min, s_hr, s_date, s_mon, s_yr;
  logic      roll_min, roll_hr, roll_day, roll_mon, roll_yr, cent_flip;
  logic [7:0] dow_nx, mon_nx;

  assign sec_wr  = wr_en && (wr_addr == A_SEC);
  // a tick that meets a host write is held one cycle
  assign cal_adv = (sec_tick | pend_q) & ~wr_en;

  always_comb begin
    s_sec  = bcd_wrap(sec_q, 8'h59, 8'h00);
    s_min  = bcd_wrap(min_q, 8'h59, 8'h00);
    s_hr   = hour_advance(hour_q[6:0]);
    s_date = bcd_wrap(date_q, month_end(mon_q[4:0], year_q), 8'h01);
    s_mon  = bcd_wrap({3'b000, mon_q[4:0]}, 8'h12, 8'h01);
    s_yr   = bcd_wrap(year_q, 8'h99, 8'h00);

    roll_min  = s_sec.carry;
    roll_hr   = roll_min & s_min.carry;
    roll_day  = roll_hr & s_hr.carry;
    roll_mon  = roll_day & s_date.carry;
    roll_yr   = roll_mon & s_mon.carry;
    cent_flip = roll_yr & s_yr.carry;

    dow_nx = (dow_q == 8'd7) ? 8'd1 : dow_q + 8'd1;
    mon_nx = s_mon.val | {mon_q[7] ^ cent_flip, 7'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
      dow_q  <= 8'h01;
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
    end else begin
      pend_q <= (sec_tick | pend_q) & wr_en & ~sec_wr;
      if (wr_en) begin
        case (wr_addr)
          A_SEC:   sec_q  <= {1'b0, wr_data[6:0]};
          A_MIN:   min_q  <= {1'b0, wr_data[6:0]};
          A_HOUR:  hour_q <= {1'b0, wr_data[6:0]};
          A_DOW:   dow_q  <= {5'b0, wr_data[2:0]};
          A_DATE:  date_q <= {2'b0, wr_data[5:0]};
          A_MON:   mon_q  <= {wr_data[7], 2'b0, wr_data[4:0]};
          A_YEAR:  year_q <= wr_data;
          default: ;
        endcase
      end else if (cal_adv) begin
        sec_q <= s_sec.val;
        if (roll_min) min_q <= s_min.val;
        if (roll_hr)  hour_q <= s_hr.val;
        if (roll_day) begin
          dow_q  <= dow_nx;
          date_q <= s_date.val;
        end
        if (roll_mon) mon_q <= mon_nx;
        if (roll_yr)  year_q <= s_yr.val;
      end
    end
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_phase,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       sqw_out
);
  // DIV_BITS must be at least 4 so the 1 Hz tap is above the fixed taps
  logic [DIV_BITS-1:0] div_q;
  logic                sec_tick;
  logic                cal_adv;
  logic                halt_q;
  logic [RATE_W-1:0]   rate_q;
  logic                stop_flag_q;
  logic [7:0]          sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q;
  logic [2:0]          sqw_taps;
  logic                div_clr, ctrl_wr, stat_wr;

  assign div_clr  = wr_en && (wr_addr == A_SEC);
  assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
  assign stat_wr  = wr_en && (wr_addr == A_STAT);
  assign sqw_taps = {div_q[DIV_BITS-1], div_q[2], div_q[1]};

  rtc_prescaler #(.DIV_BITS(DIV_BITS)) u_pre (
    .clk(clk), .rst_n(rst_n), .osc_phase(osc_phase), .halt(halt_q),
    .div_clr(div_clr), .div_q(div_q), .sec_tick(sec_tick)
  );

  rtc_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .stat_wr(stat_wr),
    .wr_halt(wr_data[7]), .wr_rate(wr_data[RATE_W-1:0]),
    .halt_q(halt_q), .rate_q(rate_q), .stop_flag_q(stop_flag_q)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sec_tick(sec_tick), .cal_adv(cal_adv),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .dow_q(dow_q),
    .date_q(date_q), .mon_q(mon_q), .year_q(year_q)
  );

  rtc_sqw_mux u_sqw (
    .taps(sqw_taps), .osc_phase(osc_phase), .rate(rate_q), .halt(halt_q), .sqw(sqw_out)
  );

  always_comb begin
    case (rd_addr)
      A_SEC:   rd_data = sec_q;
      A_MIN:   rd_data = min_q;
      A_HOUR:  rd_data = hour_q;
      A_DOW:   rd_data = dow_q;
      A_DATE:  rd_data = date_q;
      A_MON:   rd_data = mon_q;
      A_YEAR:  rd_data = year_q;
      A_CTRL:  rd_data = {halt_q, 5'b0, rate_q};
      A_STAT:  rd_data = {stop_flag_q, 7'b0};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int DIV_BITS = 15
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [3:0]          wr_addr,
  input logic [DIV_BITS-1:0] div_q,
  input logic                halt_q,
  input logic                stop_flag_q,
  input logic                sec_tick,
  input logic                cal_adv,
  input logic [7:0]          sec_q,
  input logic [7:0]          min_q,
  input logic [7:0]          hour_q,
  input logic                sqw_out
);
  // R8
  sec_wr_clears_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd0) |=> (div_q == '0));

  // R8
  tick_wraps_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (div_q == '0));

  // R11
  halt_freezes_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !(wr_en && wr_addr == 4'd0)) |=> $stable(div_q));

  // R11
  halt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_q) |-> stop_flag_q);

  // R11
  halt_quiets_sqw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> !sqw_out);

  // R1
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_adv && sec_q == 8'h59) |=> (sec_q == 8'h00));

  // R3
  pm_midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_adv && sec_q == 8'h59 && min_q == 8'h59 && hour_q == 8'h71) |=> (hour_q == 8'h52));
endmodule

bind bcd_rtc_core rtc_core_chk #(.DIV_BITS(DIV_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .div_q(div_q),
  .halt_q(halt_q), .stop_flag_q(stop_flag_q), .sec_tick(sec_tick), .cal_adv(cal_adv),
  .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .sqw_out(sqw_out)
);

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  localparam int TB_DIV = 4;
  localparam int NV     = 19;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_phase = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = 4'd0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] rd_addr = 4'd0;
  logic [7:0] rd_data;
  logic       sqw_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_rtc_core #(.DIV_BITS(TB_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .osc_phase(osc_phase), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .sqw_out(sqw_out)
  );

  // {sec,min,hour,dow,date,month,year} written, then the same after one second
  localparam logic [111:0] VECS [NV] = '{
    {56'h56_34_12_03_15_06_23, 56'h57_34_12_03_15_06_23}, // R1
    {56'h59_59_09_03_15_06_23, 56'h00_00_10_03_15_06_23}, // R1 R2
    {56'h59_59_19_04_15_06_23, 56'h00_00_20_04_15_06_23}, // R2
    {56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_81_00}, // R6 R7
    {56'h59_59_23_02_31_92_99, 56'h00_00_00_03_01_01_00}, // R6
    {56'h59_59_23_05_28_02_23, 56'h00_00_00_06_01_03_23}, // R5
    {56'h59_59_23_05_28_02_24, 56'h00_00_00_06_29_02_24}, // R5
    {56'h59_59_23_06_29_02_24, 56'h00_00_00_07_01_03_24}, // R5 R7
    {56'h59_59_23_01_28_02_00, 56'h00_00_00_02_29_02_00}, // R5
    {56'h59_59_23_01_28_02_96, 56'h00_00_00_02_29_02_96}, // R5
    {56'h59_59_23_01_30_04_10, 56'h00_00_00_02_01_05_10}, // R4
    {56'h59_59_23_01_30_01_10, 56'h00_00_00_02_31_01_10}, // R4
    {56'h59_59_23_01_30_11_10, 56'h00_00_00_02_01_12_10}, // R4
    {56'h59_59_23_01_30_09_07, 56'h00_00_00_02_01_10_07}, // R4
    {56'h59_59_23_04_31_12_12, 56'h00_00_00_05_01_01_13}, // R4 R6
    {56'h59_59_51_03_09_05_21, 56'h00_00_72_03_09_05_21}, // R3
    {56'h59_59_71_03_09_05_21, 56'h00_00_52_04_10_05_21}, // R3 R7
    {56'h59_59_52_03_09_05_21, 56'h00_00_41_03_09_05_21}, // R3
    {56'h59_59_72_03_09_05_21, 56'h00_00_61_03_09_05_21}  // R3
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic osc(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk) osc_phase = 1'b1;
      @(negedge clk) osc_phase = 1'b0;
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset contents
    begin
      logic [7:0] rst_exp [9] = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h03, 8'h80};
      for (int a = 0; a < 9; a++) begin
        rd(4'(a), d);
        chk($sformatf("R10 reset addr %0d", a), d, rst_exp[a]);
      end
    end
    chk("R10 reset sqw", {7'b0, sqw_out}, 8'h00);

    // calendar vectors, one second each
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 7; k++) wr(4'(k), VECS[i][111-8*k -: 8]);
      osc(1 << TB_DIV);
      for (int k = 0; k < 7; k++) begin
        rd(4'(k), d);
        chk($sformatf("vec%0d addr%0d", i, k), d, VECS[i][55-8*k -: 8]);
      end
    end

    // R8 seconds write restarts the prescaler
    wr(4'd0, 8'h30);
    osc(10);
    wr(4'd0, 8'h30);
    osc((1 << TB_DIV) - 1);
    rd(4'd0, d); chk("R8 no tick before full period", d, 8'h30);
    osc(1);
    rd(4'd0, d); chk("R8 tick at full period", d, 8'h31);

    // R8 R9 1 Hz wave rises at half period
    wr(4'd7, 8'h00);
    wr(4'd0, 8'h00);
    chk("R9 1Hz low after write", {7'b0, sqw_out}, 8'h00);
    osc((1 << (TB_DIV - 1)) - 1);
    chk("R8 1Hz low before half", {7'b0, sqw_out}, 8'h00);
    osc(1);
    chk("R8 1Hz high at half", {7'b0, sqw_out}, 8'h01);
    osc(1 << (TB_DIV - 1));
    chk("R8 1Hz low at wrap", {7'b0, sqw_out}, 8'h00);

    // R9 other rates
    wr(4'd7, 8'h01);
    wr(4'd0, 8'h00);
    osc(3);
    chk("R9 rate01 low", {7'b0, sqw_out}, 8'h00);
    osc(1);
    chk("R9 rate01 high", {7'b0, sqw_out}, 8'h01);
    wr(4'd7, 8'h02);
    wr(4'd0, 8'h00);
    osc(1);
    chk("R9 rate10 low", {7'b0, sqw_out}, 8'h00);
    osc(1);
    chk("R9 rate10 high", {7'b0, sqw_out}, 8'h01);
    wr(4'd7, 8'h03);
    @(negedge clk) osc_phase = 1'b1;
    #1 chk("R9 rate11 follows osc high", {7'b0, sqw_out}, 8'h01);
    @(negedge clk) osc_phase = 1'b0;
    #1 chk("R9 rate11 follows osc low", {7'b0, sqw_out}, 8'h00);

    // R11 halt and stop flag
    wr(4'd8, 8'h00);
    rd(4'd8, d); chk("R11 flag cleared by 0", d, 8'h00);
    wr(4'd7, 8'h80);
    rd(4'd8, d); chk("R11 flag set on halt", d, 8'h80);
    rd(4'd7, d); chk("R11 ctrl reads halt", d, 8'h80);
    @(negedge clk) osc_phase = 1'b1;
    #1 chk("R11 sqw low while halted", {7'b0, sqw_out}, 8'h00);
    @(negedge clk) osc_phase = 1'b0;
    wr(4'd0, 8'h10);
    osc(40);
    rd(4'd0, d); chk("R11 no count while halted", d, 8'h10);
    wr(4'd8, 8'h00);
    wr(4'd8, 8'hFF);
    rd(4'd8, d); chk("R11 write 1 ignored", d, 8'h00);
    wr(4'd7, 8'h00);
    osc(1 << TB_DIV);
    rd(4'd0, d); chk("R11 counts after resume", d, 8'h11);
    rd(4'd8, d); chk("R11 flag stays clear on resume", d, 8'h00);

    finish_run();
  end
endmodule